// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Aggregator

This block watches sixteen asynchronous external request pins. Each pin is brought into the clock domain through a two-stage synchroniser. A rising edge on a pin latches a sticky event flag for that pin. The flag holds until one of two things clears it: software writing a 1 to the flag's position in the status register, or a one-cycle service acknowledge from the DMA engine for that flag.

A mask register chooses which flags may request service. The masked flags are ORed into a single registered request line toward the interrupt controller. If an event and a clear hit the same flag in the same clock, the event wins, so no edge is ever lost.

Software reaches the block through a plain single-cycle register port. A write is a one-cycle strobe with address and data. Read data is a combinational function of the address.

Top module: `eirq_aggregator`

## Requirements
- R1: After reset, the status register and the mask register both read 0, and `irq_req` is low.
- R2: A rising edge on `irq_in[n]` sets flag n. The flag is readable 3 clock edges after the input rises: two synchroniser stages plus the flag register. An input held high sets the flag once only and does not set it again after a clear.
- R3: The status register is at byte offset 0x10. Flag n reads at data bit n, counting the LSB as bit 0, and bits 31:16 read 0. Writing 1 to bit n clears flag n. Writing 0 leaves the flag unchanged.
- R4: When `dma_ack[n]` is high at a clock edge, flag n is cleared and all other flags are unchanged.
- R5: If flag n gets a set event and a clear (by write-1 or by `dma_ack`) at the same clock edge, flag n ends up set.
- R6: The mask register is at byte offset 0x14. Bits 15:0 are read/write, with bit n enabling flag n. Bits 31:16 read 0 and ignore writes.
- R7: `irq_req` is registered. It is high one clock after any flag is set while its mask bit is set. It goes low one clock after the last enabled flag is cleared. Flags whose mask bit is 0 never raise it.
- R8: Every address other than 0x10 and 0x14 reads 0, and writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| irq_in | input | 16 | Asynchronous external request pins |
| dma_ack | input | 16 | Per-flag DMA service acknowledge; a high bit at a clock edge clears that flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Combined registered interrupt request |

## Verification
The edge-to-request path is driven with several patterns of pin pulses and masks:
- a single low pin fully enabled;
- an unmasked top pin;
- pulses that miss the mask entirely;
- pulses that straddle the mask edge;
- complementary checkerboards;
- all pins against a sparse mask.

Together these patterns separate a wrong bit position, an inverted mask, a missing OR term, and flags that leak through a cleared mask bit.

Directed tests then cover the remaining behaviour:
- write-0 versus write-1;
- DMA acknowledge on a single flag;
- a level held high after clear, which must not set the flag again;
- the same-edge race between set and clear;
- the one-clock lag as the request drops.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned NUM_IRQ     = 16;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] STATUS_OFS = 8'h10;
  localparam logic [ADDR_W-1:0] MASK_OFS   = 8'h14;
endpackage

// File: rtl/eirq_rst_sync.sv
module eirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det #(
  parameter int unsigned N      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;
    logic              prev_q;

    always_comb sync_d = {sync_q[STAGES-2:0], pin_i[i]};

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        prev_q <= sync_q[STAGES-1];
      end
    end

    assign rise_o[i] = sync_q[STAGES-1] & ~prev_q;

    // R2: a detected rise is never reported two cycles running
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/eirq_flag_bank.sv
module eirq_flag_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] dma_clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic [N-1:0] clr_any;
  logic         upd_en;

  always_comb begin
    clr_any = sw_clr_i | dma_clr_i;
    upd_en  = (|set_i) | (|clr_any);
    // set takes priority over either clear source
    flags_d = (flags_q & ~clr_any) | set_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R2: every event leaves its flag set
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
  // R2: no flag rises without an event
  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));
  // R3/R4: a clear with no competing event empties the flag
  p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(clr_any & ~set_i)) |=> ((flags_q & $past(clr_any & ~set_i)) == '0));
  // R5: same-edge race resolves to set
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(clr_any & set_i)) |=> ((flags_q & $past(clr_any & set_i)) == $past(clr_any & set_i)));
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned N = NUM_IRQ
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [N-1:0]      flags_i,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      sw_clr_o,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned PAD_W = DATA_W - N;

  logic         hit_status;
  logic         hit_mask;
  logic         mask_we;
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;

  always_comb begin
    hit_status = (reg_addr == STATUS_OFS);
    hit_mask   = (reg_addr == MASK_OFS);
    mask_we    = reg_wr & hit_mask;
    mask_d     = reg_wdata[N-1:0];
    sw_clr_o   = (reg_wr & hit_status) ? reg_wdata[N-1:0] : '0;
    unique case (1'b1)
      hit_status: reg_rdata = {{PAD_W{1'b0}}, flags_i};
      hit_mask:   reg_rdata = {{PAD_W{1'b0}}, mask_q};
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R6: upper half of any read is zero
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_rdata[DATA_W-1:N] == '0);
  // R8: mask changes only through its own address
  p_mask_stable_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(reg_wr && hit_mask) |=> $stable(mask_q));
endmodule

// File: rtl/eirq_req_merge.sv
module eirq_req_merge #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  output logic         req_o
);
  logic req_d;
  logic req_q;

  always_comb req_d = |(flags_i & mask_i);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

  // R7: request follows masked flags with one cycle lag
  p_req_lag_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    req_q == |($past(flags_i) & $past(mask_i)));
endmodule

// File: rtl/eirq_aggregator.sv
module eirq_aggregator
  import eirq_pkg::*;
#(
  parameter int unsigned N      = NUM_IRQ,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic [N-1:0]      dma_ack,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req
);
  logic         rst_ni;
  logic [N-1:0] rise;
  logic [N-1:0] flags;
  logic [N-1:0] mask;
  logic [N-1:0] sw_clr;

  eirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  eirq_edge_det #(.N(N), .STAGES(STAGES)) u_edge (
    .clk(clk), .rst_ni(rst_ni), .pin_i(irq_in), .rise_o(rise)
  );

  eirq_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst_ni(rst_ni), .set_i(rise), .sw_clr_i(sw_clr),
    .dma_clr_i(dma_ack), .flags_o(flags)
  );

  eirq_regs #(.N(N)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .flags_i(flags), .mask_o(mask),
    .sw_clr_o(sw_clr), .reg_rdata(reg_rdata)
  );

  eirq_req_merge #(.N(N)) u_merge (
    .clk(clk), .rst_ni(rst_ni), .flags_i(flags), .mask_i(mask), .req_o(irq_req)
  );

  // R1: request low while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_ni |-> !irq_req);
endmodule

// File: tb/eirq_aggregator_tb.sv
module eirq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic [15:0] dma_ack;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_req;

  int n_run  = 0;
  int n_fail = 0;

  localparam logic [7:0] A_ST = 8'h10;
  localparam logic [7:0] A_MK = 8'h14;

  // {mask, pulses, expected irq_req}
  localparam logic [32:0] VEC [0:5] = '{
    {16'hFFFF, 16'h0001, 1'b1},
    {16'h0000, 16'h8000, 1'b0},
    {16'h00F0, 16'h000F, 1'b0},
    {16'h00F0, 16'h0180, 1'b1},
    {16'hA5A5, 16'h5A5A, 1'b0},
    {16'h8001, 16'hFFFF, 1'b1}
  };

  always #5 clk = ~clk;

  eirq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .dma_ack(dma_ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] p);
    @(negedge clk);
    irq_in = p;
    cyc(3);
    irq_in = '0;
    cyc(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; irq_in = '0; dma_ack = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);

    // R1 reset state
    rd(A_ST, v); chk("R1 status", v, 32'h0);
    rd(A_MK, v); chk("R1 mask", v, 32'h0);
    chk("R1 irq_req", {31'b0, irq_req}, 32'h0);

    // vector table: R2 R3 R7
    for (int k = 0; k < 6; k++) begin
      wr(A_MK, {16'h0, VEC[k][32:17]});
      wr(A_ST, 32'h0000_FFFF);
      pulse(VEC[k][16:1]);
      rd(A_ST, v); chk("R2 flags", v, {16'h0, VEC[k][16:1]});
      chk("R7 irq_req", {31'b0, irq_req}, {31'b0, VEC[k][0]});
    end

    // R6 mask upper bits ignore writes
    wr(A_MK, 32'hFFFF_0041);
    rd(A_MK, v); chk("R6 mask readback", v, 32'h0000_0041);

    // R3 write 0 no effect; upper status bits zero
    wr(A_ST, 32'h0000_FFFF);
    pulse(16'h0049);
    wr(A_ST, 32'hFFFF_0000);
    rd(A_ST, v); chk("R3 write0 keeps", v, 32'h0000_0049);
    // R3 write 1 clears only that bit
    wr(A_ST, 32'h0000_0008);
    rd(A_ST, v); chk("R3 write1 clears", v, 32'h0000_0041);

    // R8 unmapped address
    wr(8'h18, 32'hFFFF_FFFF);
    rd(A_ST, v); chk("R8 status kept", v, 32'h0000_0041);
    rd(A_MK, v); chk("R8 mask kept", v, 32'h0000_0041);
    rd(8'h18, v); chk("R8 unmapped read", v, 32'h0);

    // R4 DMA ack clears one flag
    @(negedge clk); dma_ack = 16'h0040;
    @(negedge clk); dma_ack = '0;
    rd(A_ST, v); chk("R4 dma clear", v, 32'h0000_0001);

    // R7 drop lag: clear last enabled flag
    chk("R7 req before clear", {31'b0, irq_req}, 32'h1);
    @(negedge clk); reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R7 req one cycle lag", {31'b0, irq_req}, 32'h1);
    @(negedge clk);
    chk("R7 req dropped", {31'b0, irq_req}, 32'h0);

    // R2 held level sets once only
    @(negedge clk); irq_in = 16'h0002;
    cyc(5);
    wr(A_ST, 32'h0000_0002);
    cyc(4);
    rd(A_ST, v); chk("R2 level no retrigger", v, 32'h0);
    irq_in = '0;
    cyc(4);

    // R2 latency: visible after third edge
    @(negedge clk); irq_in = 16'h0004;
    cyc(2);
    rd(A_ST, v); chk("R2 not yet", v, 32'h0);
    cyc(1);
    rd(A_ST, v); chk("R2 latency", v, 32'h0000_0004);
    irq_in = '0;
    wr(A_ST, 32'h0000_FFFF);
    cyc(3);

    // R5 set beats simultaneous write-1 and DMA clear
    @(negedge clk); irq_in = 16'h0020;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h20; dma_ack = 16'h0020;
    @(negedge clk);
    reg_wr = 1'b0; dma_ack = '0;
    rd(A_ST, v); chk("R5 set wins", v, 32'h0000_0020);
    irq_in = '0;

    cyc(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule